// File: doc/BRIEF.md
# Asynchronous Serial Port with Handshake Gating

This block is a full-duplex asynchronous serial port. A transmit path turns words taken from a valid/ready stream into serial frames on `ser_txd`. A receive path finds frames on `ser_rxd` and presents each word, with a framing-error flag, on a second valid/ready stream. Both paths run from one programmable tick generator at sixteen ticks per bit. Each frame carries 7, 8 or 9 data bits, selected by a plain configuration input.

The host keeps `cfg_div`, `cfg_len` and `cfg_flow` steady while frames are in flight. The transmit stream accepts a word when `tx_valid` and `tx_ready` are both high at a rising clock edge. `tx_ready` stays low while the single holding register is occupied, and that is the only back-pressure toward the host. The receive stream holds `rx_valid`, `rx_data` and `rx_ferr` unchanged until `rx_ready` takes the word. The receiver cannot be stalled: a frame that completes while a word is still pending is lost, and that loss is reported.

When `cfg_flow` is set, the peer handshake lines take effect. `peer_cts` gates when a waiting word may start. `peer_rx_en` gates whether the receiver hunts for new frames. `req_send` reflects a filled transmit holding register, and `rdy_recv` reflects an empty receive register. All three serial-side inputs pass through a two-stage synchronizer before use.

Top module: `sercomm_port`

## Requirements
- R1: The transmit line idles high. A frame is one low start bit, then the data bits least significant first, then one high stop bit.
- R2: A bit lasts 16*cfg_div clock cycles in both directions. A cfg_div of 0 acts as 1.
- R3: cfg_len selects the data length: 2'b00 is 7 bits, 2'b01 is 8 bits, 2'b10 is 9 bits, and 2'b11 is 8 bits. Transmit sends only the low bits of tx_data, and receive returns zeros above the data length.
- R4: tx_ready is high exactly when the transmit holding register is empty. Accepted words go out in the order they were accepted.
- R5: With cfg_flow=1, a waiting word starts a frame only while the synchronized peer_cts is high. Otherwise it stays in the holding register and the line stays high.
- R6: peer_cts is looked at only when a frame starts. Dropping it mid-frame lets that frame finish, and the next word then waits.
- R7: req_send is high while cfg_flow=1 and the holding register has a word that has not started. It is low whenever cfg_flow=0.
- R8: rdy_recv is high while cfg_flow=1 and no received word is pending. It is low whenever cfg_flow=0.
- R9: With cfg_flow=1 and peer_rx_en low, the receiver starts no new frame, so nothing is delivered. With cfg_flow=0, peer_rx_en has no effect.
- R10: A start bit counts only if the line is still low at the middle of the bit. A low pulse shorter than half a bit produces no word.
- R11: A low stop bit delivers the word with rx_ferr=1. The receiver then waits for the line to go high before it looks for the next start bit.
- R12: rx_valid, rx_data and rx_ferr stay stable until rx_ready is high. A frame that completes while a word is pending is dropped and sets rx_ovr. rx_ovr clears when the pending word is taken.
- R13: After reset, ser_txd=1, tx_ready=1, rx_valid=0 and rx_ovr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Clock cycles per oversampling tick |
| cfg_len | input | 2 | Data length select |
| cfg_flow | input | 1 | Enables the peer handshake |
| tx_data | input | 9 | Word to transmit |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Holding register is free |
| rx_data | output | 9 | Received word |
| rx_ferr | output | 1 | Received word had a low stop bit |
| rx_valid | output | 1 | A received word is pending |
| rx_ready | input | 1 | Host takes the pending word |
| rx_ovr | output | 1 | A frame was lost behind the pending word |
| ser_txd | output | 1 | Serial transmit line |
| ser_rxd | input | 1 | Serial receive line (asynchronous) |
| peer_cts | input | 1 | Peer permits transmission (asynchronous) |
| peer_rx_en | input | 1 | Peer permits reception (asynchronous) |
| req_send | output | 1 | Transmit word waiting |
| rdy_recv | output | 1 | Receive register empty |

## Verification
The assertions assume that the configuration inputs change only while both paths are idle, since a length or rate change mid-frame has no defined result. They also assume that the serial line holds each bit for a whole bit time at the programmed rate. The bench changes `cfg_div`, `cfg_len` and `cfg_flow` only after both expected-word queues have drained and the line has been quiet for several frame times. It drives its serial frames with exactly 16*cfg_div cycles per bit. Handshake inputs are changed away from clock edges and held for many cycles, so the two-stage synchronizer never decides a check alone.

// File: rtl/sercomm_pkg.sv
package sercomm_pkg;

  localparam int WORD_W = 9;
  localparam int OVS    = 16;
  localparam int OVS_W  = $clog2(OVS);
  localparam int BIT_W  = $clog2(WORD_W + 1);

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_STOP
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT_HIGH
  } rx_state_e;

  // data bits per frame for a length code
  function automatic logic [BIT_W-1:0] len_bits(input logic [1:0] code);
    case (code)
      2'b00:   len_bits = BIT_W'(7);
      2'b10:   len_bits = BIT_W'(9);
      default: len_bits = BIT_W'(8);
    endcase
  endfunction

endpackage

// File: rtl/sercomm_sync.sv
module sercomm_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= RST_VAL;
    else        pipe[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= RST_VAL;
      else        pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/sercomm_baud.sv
module sercomm_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (div == '0) ? '0 : div - DIV_W'(1);
  assign tick = (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + DIV_W'(1);
  end

  // R2: with a steady divider above one, ticks never come back to back
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div > DIV_W'(1)) |=> (!tick || !$stable(div)));

endmodule

// File: rtl/sercomm_tx.sv
module sercomm_tx
  import sercomm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        len,
  input  logic              flow_en,
  input  logic              cts_ok,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              txd,
  output logic              hold_full
);

  tx_state_e         st;
  logic              hold_v;
  logic [WORD_W-1:0] hold_d;
  logic [WORD_W-1:0] sh;
  logic [OVS_W-1:0]  tcnt;
  logic [BIT_W-1:0]  bidx;
  logic [BIT_W-1:0]  nb;
  logic              launch;
  logic              bit_end;

  assign nb        = len_bits(len);
  assign in_ready  = !hold_v;
  assign hold_full = hold_v;
  assign bit_end   = tick && (tcnt == OVS_W'(OVS - 1));
  assign launch    = (st == TX_IDLE) && tick && hold_v && (!flow_en || cts_ok);

  // holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
    end else if (in_valid && !hold_v) begin
      hold_v <= 1'b1;
      hold_d <= in_data;
    end else if (launch) begin
      hold_v <= 1'b0;
    end
  end

  // frame sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= TX_IDLE;
      txd  <= 1'b1;
      sh   <= '0;
      tcnt <= '0;
      bidx <= '0;
    end else begin
      if (st != TX_IDLE && tick && !bit_end) tcnt <= tcnt + OVS_W'(1);
      case (st)
        TX_IDLE: begin
          if (launch) begin
            sh   <= hold_d;
            st   <= TX_START;
            txd  <= 1'b0;
            tcnt <= '0;
          end
        end
        TX_START: begin
          if (bit_end) begin
            st   <= TX_DATA;
            txd  <= sh[0];
            sh   <= sh >> 1;
            bidx <= '0;
            tcnt <= '0;
          end
        end
        TX_DATA: begin
          if (bit_end) begin
            tcnt <= '0;
            if (bidx == nb - BIT_W'(1)) begin
              st  <= TX_STOP;
              txd <= 1'b1;
            end else begin
              txd  <= sh[0];
              sh   <= sh >> 1;
              bidx <= bidx + BIT_W'(1);
            end
          end
        end
        default: begin
          if (bit_end) begin
            st   <= TX_IDLE;
            tcnt <= '0;
          end
        end
      endcase
    end
  end

  // R1: line is high whenever no frame is under way
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_IDLE) |-> txd);

  // R5: a frame only begins from a cycle where the handshake permitted it
  assert_cts_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_START && $past(st) == TX_IDLE) |-> $past(!flow_en || cts_ok));

  // R4: a waiting word is neither lost nor altered while a frame runs
  assert_hold_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && st != TX_IDLE) |=> (hold_v && $stable(hold_d)));

endmodule

// File: rtl/sercomm_rx.sv
module sercomm_rx
  import sercomm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        len,
  input  logic              flow_en,
  input  logic              enr_ok,
  input  logic              rxd,
  output logic [WORD_W-1:0] out_data,
  output logic              out_ferr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              ovr
);

  rx_state_e         st;
  logic [WORD_W-1:0] sh;
  logic [OVS_W-1:0]  cnt;
  logic [BIT_W-1:0]  bidx;
  logic [BIT_W-1:0]  nb;
  logic [BIT_W-1:0]  shamt;
  logic              bit_end;
  logic              half_bit;

  assign nb       = len_bits(len);
  assign shamt    = BIT_W'(WORD_W) - nb;
  assign bit_end  = tick && (cnt == OVS_W'(OVS - 1));
  assign half_bit = tick && (cnt == OVS_W'(OVS / 2 - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      sh        <= '0;
      cnt       <= '0;
      bidx      <= '0;
      out_data  <= '0;
      out_ferr  <= 1'b0;
      out_valid <= 1'b0;
      ovr       <= 1'b0;
    end else begin
      if (out_valid && out_ready) begin
        out_valid <= 1'b0;
        ovr       <= 1'b0;
      end
      if (st != RX_IDLE && st != RX_WAIT_HIGH && tick) cnt <= cnt + OVS_W'(1);
      case (st)
        RX_IDLE: begin
          if (tick && !rxd && (!flow_en || enr_ok)) begin
            st  <= RX_START;
            cnt <= '0;
          end
        end
        RX_START: begin
          if (half_bit) begin
            cnt  <= '0;
            bidx <= '0;
            st   <= rxd ? RX_IDLE : RX_DATA;
          end
        end
        RX_DATA: begin
          if (bit_end) begin
            cnt <= '0;
            sh  <= {rxd, sh[WORD_W-1:1]};
            if (bidx == nb - BIT_W'(1)) st <= RX_STOP;
            else                        bidx <= bidx + BIT_W'(1);
          end
        end
        RX_STOP: begin
          if (bit_end) begin
            cnt <= '0;
            st  <= rxd ? RX_IDLE : RX_WAIT_HIGH;
            if (out_valid && !out_ready) begin
              ovr <= 1'b1;
            end else begin
              out_valid <= 1'b1;
              out_data  <= sh >> shamt;
              out_ferr  <= !rxd;
            end
          end
        end
        default: begin
          if (rxd) st <= RX_IDLE;
        end
      endcase
    end
  end

  // R12: a pending word holds still until the host takes it
  assert_hold_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ferr)));

  // R12: taking the pending word clears the loss flag
  assert_ovr_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !ovr);

  // R9: hunting only starts while the peer allows reception
  assert_enr_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_START && $past(st) == RX_IDLE) |-> $past(!flow_en || enr_ok));

  // R11: after a bad stop bit, nothing starts until the line has been high
  assert_wait_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_WAIT_HIGH && !rxd) |=> (st == RX_WAIT_HIGH));

endmodule

// File: rtl/sercomm_port.sv
module sercomm_port
  import sercomm_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_flow,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_ferr,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              rx_ovr,
  output logic              ser_txd,
  input  logic              ser_rxd,
  input  logic              peer_cts,
  input  logic              peer_rx_en,
  output logic              req_send,
  output logic              rdy_recv
);

  localparam int           NSYNC    = 3;
  localparam logic [NSYNC-1:0] SYNC_RST = 3'b100;

  logic [NSYNC-1:0] async_in;
  logic [NSYNC-1:0] synced;
  logic             rxd_s;
  logic             cts_s;
  logic             enr_s;
  logic             tick;
  logic             hold_full;

  assign async_in = {ser_rxd, peer_cts, peer_rx_en};
  assign {rxd_s, cts_s, enr_s} = synced;

  sercomm_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (async_in),
    .q     (synced)
  );

  sercomm_baud #(.DIV_W(DIV_W)) u_baud (
    .clk   (clk),
    .rst_n (rst_n),
    .div   (cfg_div),
    .tick  (tick)
  );

  sercomm_tx u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .len       (cfg_len),
    .flow_en   (cfg_flow),
    .cts_ok    (cts_s),
    .in_data   (tx_data),
    .in_valid  (tx_valid),
    .in_ready  (tx_ready),
    .txd       (ser_txd),
    .hold_full (hold_full)
  );

  sercomm_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .len       (cfg_len),
    .flow_en   (cfg_flow),
    .enr_ok    (enr_s),
    .rxd       (rxd_s),
    .out_data  (rx_data),
    .out_ferr  (rx_ferr),
    .out_valid (rx_valid),
    .out_ready (rx_ready),
    .ovr       (rx_ovr)
  );

  assign req_send = cfg_flow && hold_full;
  assign rdy_recv = cfg_flow && !rx_valid;

endmodule

// File: tb/sercomm_port_bench.sv
module sercomm_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_div;
  logic [1:0]  cfg_len;
  logic        cfg_flow;
  logic [8:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready;
  logic [8:0]  rx_data;
  logic        rx_ferr;
  logic        rx_valid;
  logic        rx_ready;
  logic        rx_ovr;
  logic        ser_txd;
  logic        ser_rxd;
  logic        peer_cts;
  logic        peer_rx_en;
  logic        req_send;
  logic        rdy_recv;

  int nchk = 0;
  int nerr = 0;
  int tx_seen = 0;
  int rx_got = 0;
  int txq[$];
  int rxq[$];
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sercomm_port u_sercomm_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_div    (cfg_div),
    .cfg_len    (cfg_len),
    .cfg_flow   (cfg_flow),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .rx_data    (rx_data),
    .rx_ferr    (rx_ferr),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .rx_ovr     (rx_ovr),
    .ser_txd    (ser_txd),
    .ser_rxd    (ser_rxd),
    .peer_cts   (peer_cts),
    .peer_rx_en (peer_rx_en),
    .req_send   (req_send),
    .rdy_recv   (rdy_recv)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bitp();
    return 16 * ((cfg_div == 16'd0) ? 1 : int'(cfg_div));
  endfunction

  function automatic int nbits();
    return (cfg_len == 2'b00) ? 7 : (cfg_len == 2'b10) ? 9 : 8;
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // driver: queue the expected frame, then hand the word over
  task automatic send_word(input logic [8:0] d);
    int nb;
    nb = nbits();
    txq.push_back((nb << 16) | (int'(d) & ((1 << nb) - 1)));
    while (!tx_ready) step(1);
    tx_data  = d;
    tx_valid = 1'b1;
    step(1);
    tx_valid = 1'b0;
  endtask

  task automatic ser_frame(input logic [8:0] d, input logic stopv, input int tail_low);
    int p;
    p = bitp();
    ser_rxd = 1'b0;
    step(p);
    for (int i = 0; i < nbits(); i++) begin
      ser_rxd = d[i];
      step(p);
    end
    ser_rxd = stopv;
    step(p);
    if (tail_low > 0) begin
      ser_rxd = 1'b0;
      step(tail_low);
    end
    ser_rxd = 1'b1;
  endtask

  task automatic expect_rx(input logic [8:0] d, input logic ferr);
    rxq.push_back((int'(ferr) << 9) | int'(d));
  endtask

  task automatic drain();
    while (txq.size() != 0 || rxq.size() != 0 || !tx_ready) step(1);
    step(12 * bitp());
  endtask

  // transmit monitor: decode the line at mid-bit and compare with the queue
  initial begin
    logic       prev;
    logic [8:0] got;
    int         p;
    int         nb;
    int         item;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && prev && !ser_txd) begin
        tx_seen++;
        p   = bitp();
        got = '0;
        if (txq.size() == 0) begin
          item = -1;
          nb   = nbits();
        end else begin
          item = txq.pop_front();
          nb   = item >> 16;
        end
        repeat (p / 2) @(negedge clk);
        chk("R1 R2 start bit", int'(ser_txd), 0);
        for (int i = 0; i < nb; i++) begin
          repeat (p) @(negedge clk);
          got[i] = ser_txd;
        end
        repeat (p) @(negedge clk);
        chk("R1 R2 stop bit", int'(ser_txd), 1);
        if (item < 0) chk("R4 unexpected tx frame", int'(got), -1);
        else          chk("R1 R2 R3 R4 tx word", int'(got), item & 16'hffff);
      end
      prev = ser_txd;
    end
  end

  // receive monitor: every handshake pops one expected word
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && rx_valid && rx_ready) begin
        rx_got++;
        if (rxq.size() == 0)
          chk("R9 R10 unexpected rx word", int'({rx_ferr, rx_data}), -1);
        else
          chk("R1 R2 R3 R11 R12 rx word", int'({rx_ferr, rx_data}), rxq.pop_front());
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int s0;
    int g0;
    rst_n      = 1'b0;
    cfg_div    = 16'd2;
    cfg_len    = 2'b01;
    cfg_flow   = 1'b0;
    tx_data    = '0;
    tx_valid   = 1'b0;
    rx_ready   = 1'b1;
    ser_rxd    = 1'b1;
    peer_cts   = 1'b0;
    peer_rx_en = 1'b0;
    step(5);
    rst_n = 1'b1;
    step(3);

    // R13 reset state, R7 R8 handshake outputs low with flow off
    chk("R13 txd idle", int'(ser_txd), 1);
    chk("R13 tx_ready", int'(tx_ready), 1);
    chk("R13 rx_valid", int'(rx_valid), 0);
    chk("R13 rx_ovr", int'(rx_ovr), 0);
    chk("R7 req_send flow off", int'(req_send), 0);
    chk("R8 rdy_recv flow off", int'(rdy_recv), 0);

    // R1 eight-bit frames both ways
    send_word(9'h0A5);
    send_word(9'h03C);
    expect_rx(9'h05A, 1'b0);
    ser_frame(9'h05A, 1'b1, 0);
    drain();

    // R3 seven bits: upper bits of tx_data are not sent
    cfg_len = 2'b00;
    send_word(9'h1D5);
    expect_rx(9'h02B, 1'b0);
    ser_frame(9'h02B, 1'b1, 0);
    drain();

    // R3 nine bits
    cfg_len = 2'b10;
    send_word(9'h1C3);
    expect_rx(9'h155, 1'b0);
    ser_frame(9'h155, 1'b1, 0);
    drain();

    // R3 code 11 behaves as eight bits
    cfg_len = 2'b11;
    send_word(9'h181);
    expect_rx(9'h0E7, 1'b0);
    ser_frame(9'h0E7, 1'b1, 0);
    drain();

    // R2 other divider values, including zero
    cfg_len = 2'b01;
    cfg_div = 16'd3;
    step(4);
    send_word(9'h096);
    expect_rx(9'h069, 1'b0);
    ser_frame(9'h069, 1'b1, 0);
    drain();
    cfg_div = 16'd0;
    step(4);
    send_word(9'h00F);
    expect_rx(9'h0F0, 1'b0);
    ser_frame(9'h0F0, 1'b1, 0);
    drain();
    cfg_div = 16'd2;
    step(4);

    // R4 back-to-back words, order kept, holding register fills
    send_word(9'h011);
    send_word(9'h022);
    chk("R4 tx_ready low while holding full", int'(tx_ready), 0);
    send_word(9'h033);
    drain();

    // R5 R7 flow on, peer not clear: word waits
    cfg_flow = 1'b1;
    peer_cts = 1'b0;
    step(4);
    s0 = tx_seen;
    send_word(9'h0C7);
    step(5 * bitp());
    chk("R5 no frame while cts low", tx_seen, s0);
    chk("R5 txd stays high", int'(ser_txd), 1);
    chk("R5 tx_ready low", int'(tx_ready), 0);
    chk("R7 req_send with word waiting", int'(req_send), 1);
    peer_cts = 1'b1;
    step(8);
    chk("R7 req_send drops after start", int'(req_send), 0);
    chk("R5 frame starts with cts high", tx_seen, s0 + 1);
    drain();

    // R6 cts dropped mid-frame: frame completes, next word waits
    s0 = tx_seen;
    send_word(9'h0E1);
    while (tx_seen == s0) step(1);
    step(bitp());
    peer_cts = 1'b0;
    send_word(9'h017);
    step(12 * bitp());
    chk("R6 frame finished, next held", tx_seen, s0 + 1);
    chk("R6 req_send with held word", int'(req_send), 1);
    chk("R6 line high after frame", int'(ser_txd), 1);
    peer_cts = 1'b1;
    drain();

    // R8 ready-to-receive follows the receive register
    peer_rx_en = 1'b1;
    rx_ready   = 1'b0;
    step(4);
    chk("R8 rdy_recv when empty", int'(rdy_recv), 1);
    expect_rx(9'h044, 1'b0);
    ser_frame(9'h044, 1'b1, 0);
    step(4);
    chk("R8 rx_valid pending", int'(rx_valid), 1);
    chk("R8 rdy_recv low when full", int'(rdy_recv), 0);
    rx_ready = 1'b1;
    step(2);
    chk("R8 rdy_recv after read", int'(rdy_recv), 1);

    // R9 receive enable low blocks frames
    peer_rx_en = 1'b0;
    step(4);
    g0 = rx_got;
    ser_frame(9'h099, 1'b1, 0);
    step(2 * bitp());
    chk("R9 no word while rx enable low", rx_got, g0);
    chk("R9 rx_valid low", int'(rx_valid), 0);
    peer_rx_en = 1'b1;
    step(4);
    expect_rx(9'h066, 1'b0);
    ser_frame(9'h066, 1'b1, 0);
    drain();
    cfg_flow   = 1'b0;
    peer_rx_en = 1'b0;
    step(4);
    expect_rx(9'h077, 1'b0);
    ser_frame(9'h077, 1'b1, 0);
    drain();

    // R10 short low pulse is not a start bit
    g0 = rx_got;
    ser_rxd = 1'b0;
    step(bitp() / 4);
    ser_rxd = 1'b1;
    step(2 * bitp());
    chk("R10 glitch ignored", rx_got, g0);
    expect_rx(9'h03A, 1'b0);
    ser_frame(9'h03A, 1'b1, 0);
    drain();

    // R11 low stop bit, line stays low a while, then a clean frame
    expect_rx(9'h0B4, 1'b1);
    ser_frame(9'h0B4, 1'b0, 2 * bitp());
    step(bitp());
    expect_rx(9'h04B, 1'b0);
    ser_frame(9'h04B, 1'b1, 0);
    drain();

    // R12 overrun: second frame lost, first word kept
    rx_ready = 1'b0;
    step(2);
    expect_rx(9'h012, 1'b0);
    ser_frame(9'h012, 1'b1, 0);
    ser_frame(9'h034, 1'b1, 0);
    step(bitp());
    chk("R12 pending word kept", int'(rx_data), 9'h012);
    chk("R12 rx_ovr set", int'(rx_ovr), 1);
    rx_ready = 1'b1;
    step(2);
    chk("R12 rx_ovr cleared", int'(rx_ovr), 0);
    chk("R12 nothing pending", int'(rx_valid), 0);
    drain();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule